// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block joins two 8-bit ports, A and B, through two independent storage paths. The forward path takes data from port A, keeps it in its own latch and can present it on port B. The reverse path does the same from port B to port A. Each path has three active-low controls: a chip enable, a latch enable and an output enable. All three are sampled on the system clock.

A path's latch follows its source port while both its chip enable and its latch enable are low. When the latch enable rises, the latch freezes on the last value it sampled. The destination port is driven only while the chip enable and the output enable are both low. Each port is split into an input bus, an output bus and a per-bit output-enable vector, so that a wrapper can build real tri-state pins. A flag reports the cycles in which both ports drive at once.

Top module: `xcvr_latched`

## Requirements
- R1: On synchronous reset (`rst` high), both latches clear to zero, both output-enable vectors are all zeros, and `bus_clash` is low. Each data output always shows the contents of its path's latch.
- R2: While a path's chip enable and latch enable are both sampled low, the latch loads the source port. The destination data output then equals the source value from the previous clock edge, with exactly one cycle of latency.
- R3: When a path's latch enable is sampled high after being low, with its chip enable low, the latch keeps the value loaded at the last low sample. Later changes on the source port do not change the destination data output.
- R4: A destination port's output-enable vector is all ones in the cycle after its path's chip enable and output enable are both sampled low. Otherwise it is all zeros.
- R5: While a path's chip enable is sampled high, its latch holds and its destination enable vector goes to all zeros, whatever its latch enable and output enable are.
- R6: With chip enable low, latch enable high and output enable low, the destination port drives the held value.
- R7: The B-to-A path obeys R2 to R6 with its own controls and port B as its source. The controls and data of one path never affect the other path.
- R8: `bus_clash` is high exactly in the cycles when the port A and port B enable vectors are both nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Data arriving on port A |
| a_out | output | 8 | Reverse-path latch contents for port A |
| a_oe | output | 8 | Per-bit drive enable for port A |
| b_in | input | 8 | Data arriving on port B |
| b_out | output | 8 | Forward-path latch contents for port B |
| b_oe | output | 8 | Per-bit drive enable for port B |
| fwd_ce_n | input | 1 | Forward path chip enable, active low |
| fwd_le_n | input | 1 | Forward path latch enable, active low |
| fwd_oe_n | input | 1 | Forward path output enable, active low |
| rev_ce_n | input | 1 | Reverse path chip enable, active low |
| rev_le_n | input | 1 | Reverse path latch enable, active low |
| rev_oe_n | input | 1 | Reverse path output enable, active low |
| bus_clash | output | 1 | Both ports driving in the same cycle |

## Verification
A changing data stream with the latch open tells true one-cycle transparency apart from a latch that is stuck or late. Raising the latch enable and then changing the source tells a real freeze apart from a latch that keeps following. Holding the chip enable high while the other two enables stay low tells the chip enable's veto apart from plain enable decoding. The two paths are also driven with different patterns at the same time, together with a random mix of control settings. This exposes any crossed path and checks the clash flag against both drive states.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } dir_ctrl_t;
endpackage

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  dir_ctrl_t        ctrl,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst_data,
    output logic [WIDTH-1:0] dst_oe
);
    typedef struct packed {
        logic [WIDTH-1:0] store;
        logic             drv;
    } path_state_t;

    path_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ctrl.ce_n) begin
            if (!ctrl.le_n) begin
                st_d.store = src;
            end
            st_d.drv = !ctrl.oe_n;
        end else begin
            st_d.drv = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dst_data = st_q.store;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit_oe
        assign dst_oe[i] = st_q.drv;
    end

    // R2: open latch loads the source one edge later
    assert_transparent_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.ce_n && !ctrl.le_n) |=> (dst_data == $past(src)));

    // R3: a closed latch keeps its value
    assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.ce_n && ctrl.le_n) |=> $stable(dst_data));

    // R4: drive follows the enables one cycle later
    assert_drive_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.ce_n && !ctrl.oe_n) |=> (dst_oe == {WIDTH{1'b1}}));

    // R5: chip enable high vetoes drive and holds the latch
    assert_ce_veto_R5: assert property (@(posedge clk) disable iff (rst)
        ctrl.ce_n |=> (dst_oe == '0) && $stable(dst_data));
endmodule

// File: rtl/xcvr_clash_mon.sv
module xcvr_clash_mon #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_oe,
    output logic             clash
);
    assign clash = (|a_oe) && (|b_oe);
endmodule

// File: rtl/xcvr_latched.sv
module xcvr_latched
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    input  logic             fwd_ce_n,
    input  logic             fwd_le_n,
    input  logic             fwd_oe_n,
    input  logic             rev_ce_n,
    input  logic             rev_le_n,
    input  logic             rev_oe_n,
    output logic             bus_clash
);
    dir_ctrl_t fwd_ctrl, rev_ctrl;

    assign fwd_ctrl = '{ce_n: fwd_ce_n, le_n: fwd_le_n, oe_n: fwd_oe_n};
    assign rev_ctrl = '{ce_n: rev_ce_n, le_n: rev_le_n, oe_n: rev_oe_n};

    xcvr_dir_path #(.WIDTH(WIDTH)) u_fwd (
        .clk(clk), .rst(rst), .ctrl(fwd_ctrl), .src(a_in),
        .dst_data(b_out), .dst_oe(b_oe)
    );

    xcvr_dir_path #(.WIDTH(WIDTH)) u_rev (
        .clk(clk), .rst(rst), .ctrl(rev_ctrl), .src(b_in),
        .dst_data(a_out), .dst_oe(a_oe)
    );

    xcvr_clash_mon #(.WIDTH(WIDTH)) u_clash (
        .a_oe(a_oe), .b_oe(b_oe), .clash(bus_clash)
    );

    // R1: reset leaves both ports quiet and the latches empty
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (a_oe == '0) && (b_oe == '0) && (a_out == '0) && (b_out == '0));

    // R8: both paths enabled gives a clash on the next cycle
    assert_clash_R8: assert property (@(posedge clk) disable iff (rst)
        (!fwd_ce_n && !fwd_oe_n && !rev_ce_n && !rev_oe_n) |=> bus_clash);

    // R8: a disabled forward path never clashes
    assert_no_clash_R8: assert property (@(posedge clk) disable iff (rst)
        (fwd_ce_n || fwd_oe_n) |=> !bus_clash);

    // R7: reverse path drive depends only on its own enables
    assert_rev_drive_R7: assert property (@(posedge clk) disable iff (rst)
        (rev_ce_n || rev_oe_n) |=> (a_oe == '0));
endmodule

// File: tb/xcvr_latched_bench.sv
module xcvr_latched_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         fwd_ce_n = 1'b1, fwd_le_n = 1'b1, fwd_oe_n = 1'b1;
    logic         rev_ce_n = 1'b1, rev_le_n = 1'b1, rev_oe_n = 1'b1;
    logic         bus_clash;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    string req_tag = "R1";
    bit done = 1'b0;

    // reference model state
    logic [W-1:0] m_fwd_val = '0, m_rev_val = '0;
    bit           m_fwd_drv = 0, m_rev_drv = 0;

    always #10 clk = ~clk;

    xcvr_latched #(.WIDTH(W)) u_xcvr_latched (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .fwd_ce_n(fwd_ce_n), .fwd_le_n(fwd_le_n), .fwd_oe_n(fwd_oe_n),
        .rev_ce_n(rev_ce_n), .rev_le_n(rev_le_n), .rev_oe_n(rev_oe_n),
        .bus_clash(bus_clash)
    );

    // behavioural reference, advanced on each edge
    always @(posedge clk) begin
        if (rst) begin
            m_fwd_val = '0; m_rev_val = '0; m_fwd_drv = 0; m_rev_drv = 0;
        end else begin
            if (fwd_ce_n == 1'b0 && fwd_le_n == 1'b0) m_fwd_val = a_in;
            m_fwd_drv = (fwd_ce_n == 1'b0) && (fwd_oe_n == 1'b0);
            if (rev_ce_n == 1'b0 && rev_le_n == 1'b0) m_rev_val = b_in;
            m_rev_drv = (rev_ce_n == 1'b0) && (rev_oe_n == 1'b0);
        end
    end

    task automatic check(string what, logic [W-1:0] act, logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
        end
    endtask

    // compare every cycle, 5 ns after the edge
    always @(posedge clk) begin
        #5;
        if (!done) begin
            check("b_out", b_out, m_fwd_val);
            check("b_oe", b_oe, m_fwd_drv ? {W{1'b1}} : '0);
            check("a_out", a_out, m_rev_val);
            check("a_oe", a_oe, m_rev_drv ? {W{1'b1}} : '0);
            check("bus_clash", {{(W-1){1'b0}}, bus_clash},
                  {{(W-1){1'b0}}, (m_fwd_drv && m_rev_drv)});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic fwd(bit ce, bit le, bit oe, logic [W-1:0] d);
        fwd_ce_n = ce; fwd_le_n = le; fwd_oe_n = oe; a_in = d;
    endtask

    task automatic rev(bit ce, bit le, bit oe, logic [W-1:0] d);
        rev_ce_n = ce; rev_le_n = le; rev_oe_n = oe; b_in = d;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        req_tag = "R1";
        step(3);
        fwd(0, 0, 0, 8'hA5); rev(0, 0, 0, 8'h5A);
        step(2);
        rst = 1'b0;

        // R2: transparent stream on the forward path
        req_tag = "R2";
        fwd(0, 0, 0, 8'h00); rev(1, 1, 1, 8'h00);
        for (int i = 0; i < 8; i++) begin
            a_in = 8'h11 * i[7:0] + 8'h03;
            step(1);
        end

        // R3: freeze then change the source
        req_tag = "R3";
        a_in = 8'h3C; step(1);
        fwd(0, 1, 0, 8'hC3); step(1);
        a_in = 8'hFF; step(1);
        a_in = 8'h00; step(2);

        // R6: held value shown with latch closed and drive on
        req_tag = "R6";
        fwd(0, 1, 0, 8'h77); step(3);

        // R4: output enable off, latch still open
        req_tag = "R4";
        fwd(0, 0, 1, 8'h42); step(2);
        fwd(0, 0, 0, 8'h43); step(2);

        // R5: chip enable high vetoes all
        req_tag = "R5";
        fwd(1, 0, 0, 8'h99); step(2);
        a_in = 8'h66; step(2);
        fwd(1, 1, 1, 8'h12); step(1);

        // R7: reverse path alone, forward idle
        req_tag = "R7";
        fwd(1, 1, 1, 8'hEE);
        rev(0, 0, 0, 8'h81); step(1);
        b_in = 8'h18; step(1);
        rev(0, 1, 0, 8'h00); step(2);
        rev(1, 0, 0, 8'h55); step(2);

        // R8: both paths driving together, different patterns
        req_tag = "R8";
        fwd(0, 0, 0, 8'h0F); rev(0, 0, 0, 8'hF0); step(3);
        fwd(0, 0, 1, 8'h1E); step(2);
        fwd(0, 0, 0, 8'h2D); rev(0, 1, 1, 8'h00); step(2);

        // R7: random mixed controls on both paths
        req_tag = "R7";
        for (int i = 0; i < 300; i++) begin
            fwd($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 2) == 0, 8'($urandom));
            rev($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 2) == 0, 8'($urandom));
            step(1);
        end

        // R1: reset in mid run clears everything
        req_tag = "R1";
        fwd(0, 0, 0, 8'hBB); rev(0, 0, 0, 8'hCC); step(2);
        rst = 1'b1; step(2);
        rst = 1'b0; fwd(1, 1, 1, 8'h00); rev(1, 1, 1, 8'h00); step(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule